// File: doc/BRIEF.md
# Multi-Mode Operand Address Generator

This block resolves the source operand of a two-operand register-memory ALU instruction. A start strobe captures a mode code, two register indices, a 16-bit displacement field and a 2-bit size/scale code. The block reads the register file and computes the effective address. It then performs up to two dependent memory reads over a request/ready/valid read port and returns the operand, the effective address and a one-cycle done pulse. The auto-update modes also write the adjusted base register back through a register-file write port.

The register file read ports are combinational. The block drives both read indices from its captured fields and samples the data one cycle after start. Memory reads are split-phase. The request is held with a fixed address until ready is seen, and the data is taken on the first valid after that. The scale code `sc` selects d = 1 << sc, so d is 1, 2, 4 or 8. It is applied as a shift.

Top module: `opaddr_gen`

## Requirements
- R1: Mode code 0 (register) returns operand = reg[ra] with no memory request and reports ea = 0. Codes 10 to 15 behave the same way.
- R2: Mode code 1 (immediate) returns the displacement field sign-extended from bit 15 to 32 bits, with no memory request and ea = 0.
- R3: Mode code 2 (displacement) reads memory once at reg[ra] + sign-extended displacement.
- R4: Mode code 3 (register indirect) reads once at reg[ra]. Mode code 4 (indexed) reads once at reg[ra] + reg[rb].
- R5: Mode code 5 (absolute) reads once at the displacement field zero-extended to 32 bits.
- R6: Mode code 6 (memory indirect) reads at reg[ra] to obtain a pointer, then reads at the pointer. The operand is the second read's data and ea is the pointer.
- R7: Mode code 7 (post-increment) reads at reg[ra] and writes reg[ra] + d back to register ra.
- R8: Mode code 8 (pre-decrement) reads at reg[ra] − d and writes that same address back to register ra.
- R9: Mode code 9 (scaled) reads at sign-extended displacement + reg[ra] + (reg[rb] << sc).
- R10: The register write enable is asserted exactly once for each mode 7 or mode 8 instruction, in the done cycle, and never for any other mode.
- R11: The memory request stays asserted with a stable address until ready is sampled high. Read data is taken only on valid.
- R12: done is a single-cycle pulse carrying the operand and ea. A new start in the cycle after done is accepted.
- R13: After reset, done, the memory request and the register write enable are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Capture instruction fields when idle |
| mode | input | 4 | Addressing mode code |
| ra | input | 4 | Base register index |
| rb | input | 4 | Index register index |
| disp | input | 16 | Displacement / immediate / absolute field |
| sc | input | 2 | Size/scale code, d = 1 << sc |
| rf_ra_addr | output | 4 | Register file read index A |
| rf_ra_data | input | 32 | Register file read data A |
| rf_rb_addr | output | 4 | Register file read index B |
| rf_rb_data | input | 32 | Register file read data B |
| rf_we | output | 1 | Base register write enable |
| rf_waddr | output | 4 | Base register write index |
| rf_wdata | output | 32 | Base register write data |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 32 | Memory read address |
| mem_ready | input | 1 | Request accepted |
| mem_valid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |
| ea | output | 32 | Resolved effective address |
| operand | output | 32 | Resolved operand value |
| done | output | 1 | Result valid pulse |

## Verification
The hardest state to reach is the memory-indirect chain under a slow memory. Here the second request must carry the first read's data as its address and must be held through a stall on ready. The bench reaches it with a responder that varies the ready gap and the valid latency from one request to the next. Its memory contents are a hash of the address, so every pointer is a fresh value that the bench can predict. The sweep crosses every mode with boundary displacements (0, ±1, 0x7FFF, 0x8000), all four scales, and equal and unequal register pairs. Each instruction starts in the cycle after the previous done, so the back-to-back path and the reads after writeback are exercised throughout.

// File: rtl/opaddr_gen.sv
module opaddr_gen #(
  parameter int XLEN  = 32,
  parameter int RIDX  = 4,
  parameter int DISPW = 16,
  parameter int MODEW = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [MODEW-1:0] mode,
  input  logic [RIDX-1:0]  ra,
  input  logic [RIDX-1:0]  rb,
  input  logic [DISPW-1:0] disp,
  input  logic [1:0]       sc,
  output logic [RIDX-1:0]  rf_ra_addr,
  input  logic [XLEN-1:0]  rf_ra_data,
  output logic [RIDX-1:0]  rf_rb_addr,
  input  logic [XLEN-1:0]  rf_rb_data,
  output logic             rf_we,
  output logic [RIDX-1:0]  rf_waddr,
  output logic [XLEN-1:0]  rf_wdata,
  output logic             mem_req,
  output logic [XLEN-1:0]  mem_addr,
  input  logic             mem_ready,
  input  logic             mem_valid,
  input  logic [XLEN-1:0]  mem_rdata,
  output logic [XLEN-1:0]  ea,
  output logic [XLEN-1:0]  operand,
  output logic             done
);

  localparam logic [MODEW-1:0] M_REG     = MODEW'(0);
  localparam logic [MODEW-1:0] M_IMM     = MODEW'(1);
  localparam logic [MODEW-1:0] M_DISP    = MODEW'(2);
  localparam logic [MODEW-1:0] M_RIND    = MODEW'(3);
  localparam logic [MODEW-1:0] M_IDX     = MODEW'(4);
  localparam logic [MODEW-1:0] M_ABS     = MODEW'(5);
  localparam logic [MODEW-1:0] M_MIND    = MODEW'(6);
  localparam logic [MODEW-1:0] M_POSTINC = MODEW'(7);
  localparam logic [MODEW-1:0] M_PREDEC  = MODEW'(8);
  localparam logic [MODEW-1:0] M_SCALED  = MODEW'(9);
  localparam int               EXTW      = XLEN - DISPW;

  typedef enum logic [1:0] {S_IDLE, S_CALC, S_REQ, S_WAIT} st_t;

  st_t              st;
  logic [MODEW-1:0] m_q;
  logic [RIDX-1:0]  ra_q, rb_q;
  logic [DISPW-1:0] disp_q;
  logic [1:0]       sc_q;
  logic [XLEN-1:0]  addr_q;
  logic             hop_q;

  logic [XLEN-1:0] sx_disp, zx_disp, step, calc_addr;
  logic            uses_mem;

  assign sx_disp  = {{EXTW{disp_q[DISPW-1]}}, disp_q};
  assign zx_disp  = {{EXTW{1'b0}}, disp_q};
  assign step     = {{(XLEN-1){1'b0}}, 1'b1} << sc_q;
  assign uses_mem = (m_q >= M_DISP) && (m_q <= M_SCALED);

  assign rf_ra_addr = ra_q;
  assign rf_rb_addr = rb_q;
  assign rf_waddr   = ra_q;
  assign mem_req    = (st == S_REQ);
  assign mem_addr   = addr_q;

  always_comb begin
    case (m_q)
      M_DISP:   calc_addr = rf_ra_data + sx_disp;
      M_IDX:    calc_addr = rf_ra_data + rf_rb_data;
      M_ABS:    calc_addr = zx_disp;
      M_PREDEC: calc_addr = rf_ra_data - step;
      M_SCALED: calc_addr = sx_disp + rf_ra_data + (rf_rb_data << sc_q);
      default:  calc_addr = rf_ra_data;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      m_q      <= '0;
      ra_q     <= '0;
      rb_q     <= '0;
      disp_q   <= '0;
      sc_q     <= '0;
      addr_q   <= '0;
      hop_q    <= 1'b0;
      ea       <= '0;
      operand  <= '0;
      done     <= 1'b0;
      rf_we    <= 1'b0;
      rf_wdata <= '0;
    end else begin
      done  <= 1'b0;
      rf_we <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          m_q    <= mode;
          ra_q   <= ra;
          rb_q   <= rb;
          disp_q <= disp;
          sc_q   <= sc;
          st     <= S_CALC;
        end
        S_CALC: if (!uses_mem) begin
          operand <= (m_q == M_IMM) ? sx_disp : rf_ra_data;
          ea      <= '0;
          done    <= 1'b1;
          st      <= S_IDLE;
        end else begin
          addr_q <= calc_addr;
          hop_q  <= (m_q == M_MIND);
          st     <= S_REQ;
        end
        S_REQ: if (mem_ready) st <= S_WAIT;
        S_WAIT: if (mem_valid) begin
          if (hop_q) begin
            hop_q  <= 1'b0;
            addr_q <= mem_rdata;
            st     <= S_REQ;
          end else begin
            operand <= mem_rdata;
            ea      <= addr_q;
            done    <= 1'b1;
            st      <= S_IDLE;
            if (m_q == M_POSTINC) begin
              rf_we    <= 1'b1;
              rf_wdata <= addr_q + step;
            end else if (m_q == M_PREDEC) begin
              rf_we    <= 1'b1;
              rf_wdata <= addr_q;
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  a_r11_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ready |=> mem_req && $stable(mem_addr));

  a_r12_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r10_wb_in_done: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |-> done);

  a_r11_idle_at_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !mem_req);

  a_r8_predec_wb: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we && m_q == M_PREDEC |-> rf_wdata == ea);

  a_r7_postinc_wb: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we && m_q == M_POSTINC |-> rf_wdata == ea + step);

endmodule

// File: tb/sim_opaddr_gen.sv
module sim_opaddr_gen;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [3:0]  mode = '0, ra = '0, rb = '0;
  logic [15:0] disp = '0;
  logic [1:0]  sc = '0;
  logic [3:0]  rf_ra_addr, rf_rb_addr, rf_waddr;
  logic [31:0] rf_ra_data, rf_rb_data, rf_wdata;
  logic        rf_we, mem_req, done;
  logic [31:0] mem_addr, ea, operand;
  logic        mem_ready = 1'b0, mem_valid = 1'b0;
  logic [31:0] mem_rdata = '0;

  logic [31:0] rf [16];
  int checks = 0, fails = 0;
  bit finished = 0;

  int          nreq, nwb;
  logic [31:0] req_addr [2];
  logic [3:0]  wb_idx;
  logic [31:0] wb_val;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign rf_ra_data = rf[rf_ra_addr];
  assign rf_rb_data = rf[rf_rb_addr];

  opaddr_gen u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .ra(ra), .rb(rb),
    .disp(disp), .sc(sc), .rf_ra_addr(rf_ra_addr), .rf_ra_data(rf_ra_data),
    .rf_rb_addr(rf_rb_addr), .rf_rb_data(rf_rb_data), .rf_we(rf_we),
    .rf_waddr(rf_waddr), .rf_wdata(rf_wdata), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_ready(mem_ready), .mem_valid(mem_valid),
    .mem_rdata(mem_rdata), .ea(ea), .operand(operand), .done(done)
  );

  function automatic logic [31:0] memf(logic [31:0] a);
    return ((a ^ 32'hA5C3_0F1E) * 32'h0001_0193) + 32'h0000_1357;
  endfunction

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // memory responder with varying ready gap and valid latency
  initial begin
    logic [7:0] rnd;
    int gap, lat;
    bit pend;
    logic [31:0] paddr;
    rnd = 8'h3B; gap = 0; lat = 0; pend = 0; paddr = '0;
    forever begin
      @(posedge clk);
      mem_valid <= 1'b0;
      if (rf_we) begin nwb++; wb_idx = rf_waddr; wb_val = rf_wdata; end
      if (pend) begin
        if (lat == 0) begin
          mem_valid <= 1'b1; mem_rdata <= memf(paddr); pend = 0;
        end else lat--;
      end
      if (mem_req && mem_ready) begin
        if (nreq < 2) req_addr[nreq] = mem_addr;
        nreq++;
        mem_ready <= 1'b0;
        pend = 1; paddr = mem_addr;
        rnd = rnd * 8'd5 + 8'd7;
        lat = int'(rnd[3:2]) % 3;
        gap = int'(rnd[5:4]);
      end else if (mem_req && !pend && !mem_ready) begin
        if (gap == 0) mem_ready <= 1'b1; else gap--;
      end
    end
  end

  task automatic run(input int m, input int ia, input int ib, input logic [15:0] dv, input int s);
    logic [31:0] a, b, sx, stp, addr, exp_op, exp_ea, exp_wb;
    int exp_nreq, waitc;
    bit has_wb;
    a = rf[ia]; b = rf[ib];
    sx = {{16{dv[15]}}, dv};
    stp = 32'd1 << s;
    has_wb = 0; exp_wb = '0; exp_nreq = 1; addr = a;
    case (m)
      1: addr = '0;
      2: addr = a + sx;
      3: addr = a;
      4: addr = a + b;
      5: addr = {16'h0, dv};
      6: addr = a;
      7: begin addr = a; has_wb = 1; exp_wb = a + stp; end
      8: begin addr = a - stp; has_wb = 1; exp_wb = a - stp; end
      9: addr = sx + a + (b << s);
      default: addr = '0;
    endcase
    if (m == 0 || m >= 10) begin exp_op = a; exp_ea = '0; exp_nreq = 0; end
    else if (m == 1) begin exp_op = sx; exp_ea = '0; exp_nreq = 0; end
    else if (m == 6) begin exp_ea = memf(a); exp_op = memf(memf(a)); exp_nreq = 2; end
    else begin exp_ea = addr; exp_op = memf(addr); end
    nreq = 0; nwb = 0;
    mode = 4'(m); ra = 4'(ia); rb = 4'(ib); disp = dv; sc = 2'(s);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    waitc = 0;
    while (!done && waitc < 200) begin @(negedge clk); waitc++; end
    chk("R12", "done seen", 32'(done), 32'd1);
    if (m == 0 || m >= 10) begin
      chk("R1", "reg operand", operand, exp_op);
      chk("R1", "reg ea", ea, exp_ea);
    end else if (m == 1) begin
      chk("R2", "imm operand", operand, exp_op);
      chk("R2", "imm ea", ea, exp_ea);
    end else begin
      chk(m == 6 ? "R6" : m == 9 ? "R9" : m == 5 ? "R5" : m == 2 ? "R3" : "R4",
          "operand", operand, exp_op);
      chk("R3_R9_ea", "ea", ea, exp_ea);
      chk("R11", "first req addr", req_addr[0], (m == 6) ? a : addr);
    end
    chk("R11", "request count", 32'(nreq), 32'(exp_nreq));
    @(negedge clk);
    chk("R12", "done single cycle", 32'(done), 32'd0);
    chk("R10", "writeback count", 32'(nwb), has_wb ? 32'd1 : 32'd0);
    if (has_wb && nwb == 1) begin
      chk(m == 7 ? "R7" : "R8", "wb index", 32'(wb_idx), 32'(ia));
      chk(m == 7 ? "R7" : "R8", "wb value", wb_val, exp_wb);
      rf[wb_idx] = wb_val;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] dlist [6];
    int pa [3], pb [3];
    int iter;
    dlist[0] = 16'h0000; dlist[1] = 16'h0001; dlist[2] = 16'hFFFF;
    dlist[3] = 16'h7FFF; dlist[4] = 16'h8000; dlist[5] = 16'h1234;
    pa[0] = 1; pb[0] = 2; pa[1] = 5; pb[1] = 5; pa[2] = 15; pb[2] = 0;
    for (int i = 0; i < 16; i++) rf[i] = 32'h1000_0000 + 32'(i) * 32'h0101_0040;
    nreq = 0; nwb = 0; wb_idx = '0; wb_val = '0; req_addr[0] = '0; req_addr[1] = '0;
    repeat (3) @(negedge clk);
    chk("R13", "done after reset", 32'(done), 32'd0);
    chk("R13", "mem_req after reset", 32'(mem_req), 32'd0);
    chk("R13", "rf_we after reset", 32'(rf_we), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    iter = 0;
    for (int m = 0; m < 12; m++)
      for (int d = 0; d < 6; d++)
        for (int s = 0; s < 4; s++)
          for (int p = 0; p < 3; p++) begin
            iter++;
            if (iter % 4 == 0) rf[pa[p]] = 32'(iter) * 32'h0000_0003;
            else if (iter % 4 == 1) rf[pa[p]] = 32'hFFFF_FF00 + 32'(iter);
            if (pa[p] != pb[p]) rf[pb[p]] = 32'(iter) * 32'h0011_0007;
            run(m, pa[p], pb[p], dlist[d], s);
          end
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule